// File: doc/BRIEF.md
# Configurable Trip Release Timer

This block holds a protective trip output once a trip has been seen and decides when to let it go, under one of three release policies chosen by a 2-bit code. The trip output follows a trip input at once, in the same cycle. What happens after the trip input drops depends on the selected policy. The output can stay on until the current-sense input is also quiet. It can stay on for a fixed number of millisecond ticks. Or it can drop at once.

The code that has no policy of its own falls back to the current-sense policy, which is the most conservative one. A 2-bit mode output reports the policy actually in force so that a display can label it. The millisecond time base comes in as a one-cycle tick pulse. The hold-off length is a parameter counted in those ticks, 100 by default.

Top module: `trip_release_timer`

## Requirements
- R1: While reset is held, and after it, with the trip input low and no trip yet seen, trip_out is 0 and mode_ind shows the effective policy of rel_code.
- R2: trip_out is 1 in every cycle in which trip_in is 1, under any rel_code, with no cycle of delay.
- R3: With rel_code 2'b00, once a trip has been seen, trip_out stays 1 after trip_in drops for as long as cs_in is 1. It goes to 0 in the first cycle in which trip_in and cs_in are both 0.
- R4: With rel_code 2'b01, trip_out stays 1 after trip_in drops until HOLD_TICKS tick pulses have been seen, whatever cs_in does. It then goes to 0, within one tick period of the nominal delay.
- R5: With rel_code 2'b01, if trip_in returns to 1 during the hold-off, trip_out stays 1 and the tick count starts over from zero when trip_in next drops.
- R6: With rel_code 2'b10, trip_out goes to 0 in the same cycle in which trip_in drops, whatever cs_in does.
- R7: rel_code 2'b11 releases exactly as rel_code 2'b00 does.
- R8: mode_ind is 2'b00 for rel_code 2'b00 and 2'b11, 2'b01 for rel_code 2'b01, and 2'b10 for rel_code 2'b10.
- R9: cs_in alone, with no trip seen since the last release, never drives trip_out to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trip_in | input | 1 | Trip demand, 1 = trip |
| cs_in | input | 1 | Current-sense indication, 1 = current flowing |
| rel_code | input | 2 | Release policy select: 00 sense+trip, 01 timed hold-off, 10 immediate, 11 treated as 00 |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| trip_out | output | 1 | Held trip output |
| mode_ind | output | 2 | Effective policy for display |

## Verification
The bench builds the block with HOLD_TICKS set to 5 and a tick every 4 clocks. A full timed hold-off then lasts about twenty cycles, so the bench can run several complete hold-offs and a hold-off restart in a short run while keeping every counter path in use. A behavioural model predicts trip_out and mode_ind on every clock under all four codes. Direct checks then bound the length of each measured hold-off and confirm the same-cycle release and the sense-held release.

// File: rtl/trip_rel_pkg.sv
package trip_rel_pkg;

  typedef enum logic [1:0] {
    POL_SENSE = 2'b00,
    POL_TIMED = 2'b01,
    POL_NOW   = 2'b10
  } rel_pol_e;

endpackage

// File: rtl/trip_rel_rst_sync.sv
module trip_rel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/trip_rel_decode.sv
module trip_rel_decode
  import trip_rel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rel_code,
  output rel_pol_e   policy,
  output logic [1:0] mode_ind
);

  always_comb begin
    case (rel_code)
      2'b01:   policy = POL_TIMED;
      2'b10:   policy = POL_NOW;
      default: policy = POL_SENSE;
    endcase
    mode_ind = policy;
  end

  // R7: the spare code must never select a looser policy
  p_spare_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_code == 2'b11) |-> (mode_ind == 2'b00));

endmodule

// File: rtl/trip_rel_holdoff.sv
module trip_rel_holdoff #(
  parameter int HOLD_TICKS = 100,
  localparam int CW = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic done
);

  localparam logic [CW-1:0] LIMIT = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear | (tick & (cnt_q != LIMIT));
    cnt_d  = clear ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == LIMIT);

  // R4: counter saturates at the limit
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R4: without a tick the count never moves forward
  p_tick_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/trip_rel_latch.sv
module trip_rel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_in,
  input  logic release_now,
  output logic held_q
);

  logic held_d;
  logic held_en;

  always_comb begin
    held_en = trip_in | (held_q & release_now);
    held_d  = trip_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

  // R2: a seen trip is always latched
  p_trip_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trip_in |=> held_q);

  // R9: the latch only sets through the trip input
  p_set_by_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_q) |-> $past(trip_in));

endmodule

// File: rtl/trip_release_timer.sv
module trip_release_timer
  import trip_rel_pkg::*;
#(
  parameter int HOLD_TICKS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip_in,
  input  logic       cs_in,
  input  logic [1:0] rel_code,
  input  logic       tick_ms,
  output logic       trip_out,
  output logic [1:0] mode_ind
);

  logic     rst_int_n;
  rel_pol_e policy;
  logic     held_q;
  logic     hold_done;
  logic     hold_clear;
  logic     release_now;

  trip_rel_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  trip_rel_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rel_code (rel_code),
    .policy   (policy),
    .mode_ind (mode_ind)
  );

  always_comb begin
    hold_clear = trip_in | ~held_q;
    case (policy)
      POL_TIMED: release_now = ~trip_in & hold_done;
      POL_NOW:   release_now = ~trip_in;
      default:   release_now = ~trip_in & ~cs_in;
    endcase
    trip_out = trip_in | (held_q & ~release_now);
  end

  trip_rel_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clear (hold_clear),
    .tick  (tick_ms),
    .done  (hold_done)
  );

  trip_rel_latch u_latch (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .trip_in     (trip_in),
    .release_now (release_now),
    .held_q      (held_q)
  );

  // R3: sense policy keeps the output on while current flows
  p_sense_hold_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (policy == POL_SENSE && held_q && cs_in) |-> trip_out);

  // R5: a returning trip restarts the hold-off
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    trip_in |=> !hold_done);

  // R6: immediate policy drops as soon as the trip is gone
  p_now_drop_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (policy == POL_NOW && !trip_in) |-> !trip_out);

  // R9: nothing held and no trip means no output
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!trip_in && !held_q) |-> !trip_out);

endmodule

// File: tb/trip_release_timer_bench.sv
`timescale 1ns/1ps
module trip_release_timer_bench;

  localparam int HOLD = 5;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       trip_in;
  logic       cs_in;
  logic [1:0] rel_code;
  logic       tick_ms;
  logic       trip_out;
  logic [1:0] mode_ind;

  always #5 clk = ~clk;

  trip_release_timer #(.HOLD_TICKS(HOLD)) u_trip_release_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .trip_in  (trip_in),
    .cs_in    (cs_in),
    .rel_code (rel_code),
    .tick_ms  (tick_ms),
    .trip_out (trip_out),
    .mode_ind (mode_ind)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string tag   = "R1";
  bit    done  = 0;

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  // tick source
  int tdc = 0;
  initial tick_ms = 1'b0;
  always @(negedge clk) begin
    tdc = (tdc + 1) % TDIV;
    tick_ms = (tdc == 0);
  end

  // behavioural reference model
  int m_rs  = 0;
  bit m_lat = 0;
  int m_cnt = 0;

  function automatic int eff_code(input logic [1:0] c);
    return (c == 2'b11) ? 0 : int'(c);
  endfunction

  function automatic bit m_release();
    if (trip_in) return 0;
    case (eff_code(rel_code))
      1:       return m_cnt >= HOLD;
      2:       return 1;
      default: return !cs_in;
    endcase
  endfunction

  function automatic bit m_out();
    return trip_in || (m_lat && !m_release());
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs = 0; m_lat = 0; m_cnt = 0;
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      bit rel;
      rel = m_release();
      if (trip_in || !m_lat) m_cnt = 0;
      else if (tick_ms && m_cnt < HOLD) m_cnt++;
      if (trip_in) m_lat = 1;
      else if (rel) m_lat = 0;
    end
  end

  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk(trip_out == m_out(), tag, int'(trip_out), int'(m_out()));
      chk(mode_ind == 2'(eff_code(rel_code)), "R8", int'(mode_ind), eff_code(rel_code));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // measure cycles from now until trip_out falls, bounded
  task automatic wait_release(output int n);
    n = 0;
    while (n < 200) begin
      @(negedge clk); #2;
      n++;
      if (!trip_out) break;
    end
  endtask

  initial begin
    int el;
    rst_n = 0; trip_in = 0; cs_in = 0; rel_code = 2'b00;
    cyc(3); #2;
    chk(trip_out == 1'b0, "R1", int'(trip_out), 0);
    chk(mode_ind == 2'b00, "R1", int'(mode_ind), 0);
    @(negedge clk); rst_n = 1;
    cyc(4); #2;
    chk(trip_out == 1'b0, "R1", int'(trip_out), 0);

    // R9: sense alone
    tag = "R9";
    @(negedge clk); cs_in = 1;
    cyc(5); #2;
    chk(trip_out == 1'b0, "R9", int'(trip_out), 0);
    @(negedge clk); cs_in = 0;

    // R2 + R3: sense policy
    tag = "R3";
    @(negedge clk); trip_in = 1; #2;
    chk(trip_out == 1'b1, "R2", int'(trip_out), 1);
    @(negedge clk); cs_in = 1;
    cyc(2);
    @(negedge clk); trip_in = 0;
    cyc(6); #2;
    chk(trip_out == 1'b1, "R3", int'(trip_out), 1);
    @(negedge clk); cs_in = 0; #2;
    chk(trip_out == 1'b0, "R3", int'(trip_out), 0);
    cyc(3);

    // R6: immediate policy
    tag = "R6";
    @(negedge clk); rel_code = 2'b10; trip_in = 1; cs_in = 1; #2;
    chk(trip_out == 1'b1, "R2", int'(trip_out), 1);
    cyc(3);
    @(negedge clk); trip_in = 0; #2;
    chk(trip_out == 1'b0, "R6", int'(trip_out), 0);
    @(negedge clk); cs_in = 0;
    cyc(3);

    // R4: timed policy, sense active throughout
    tag = "R4";
    @(negedge clk); rel_code = 2'b01; trip_in = 1; cs_in = 1;
    cyc(3);
    @(negedge clk); trip_in = 0;
    wait_release(el);
    chk(el >= (HOLD - 1) * TDIV && el <= (HOLD + 1) * TDIV, "R4", el, HOLD * TDIV);
    @(negedge clk); cs_in = 0;
    cyc(4);

    // R5: retrigger mid hold-off
    tag = "R5";
    @(negedge clk); trip_in = 1;
    cyc(2);
    @(negedge clk); trip_in = 0;
    cyc(2 * TDIV);
    @(negedge clk); trip_in = 1; #2;
    chk(trip_out == 1'b1, "R5", int'(trip_out), 1);
    @(negedge clk); trip_in = 0;
    wait_release(el);
    chk(el >= (HOLD - 1) * TDIV && el <= (HOLD + 1) * TDIV, "R5", el, HOLD * TDIV);
    cyc(4);

    // R7: spare code behaves as sense policy
    tag = "R7";
    @(negedge clk); rel_code = 2'b11; trip_in = 1; cs_in = 1;
    cyc(2);
    @(negedge clk); trip_in = 0;
    cyc(3 * HOLD * TDIV); #2;
    chk(trip_out == 1'b1, "R7", int'(trip_out), 1);
    @(negedge clk); cs_in = 0; #2;
    chk(trip_out == 1'b0, "R7", int'(trip_out), 0);
    cyc(2);

    // R8: mode indicator for every code
    tag = "R8";
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); rel_code = 2'(c); #2;
      chk(mode_ind == 2'((c == 3) ? 0 : c), "R8", int'(mode_ind), (c == 3) ? 0 : c);
    end
    cyc(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule